// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two byte-wide buses, A and B, and keeps one storage register for each transfer direction. The A-side register loads bus A on the rising edge of its own capture clock. The B-side register loads bus B on the rising edge of a second, separate capture clock. Loading happens on every such edge, whatever the enable and direction inputs are. An active-low enable and a direction input decide which bus the block drives, if either. A per-side select then picks what goes onto the driven bus: live data from the opposite bus, or the value held in the opposite register.

Each tri-state bus is modelled as three vectors: an input, an output and an output enable. A wide instance is a row of independent byte sections, two by default. Each section has its own clocks, selects, direction and enable, so it can act as a transceiver on its own. Pin electrical behaviour and pin timing are not modelled.

Top module: `dual_xcvr_reg`

## Requirements
- R1: At a rising edge of a section's `clk_ab` bit, its A-side register loads the resolved value of bus A. At a rising edge of its `clk_ba` bit, its B-side register loads the resolved value of bus B. The resolved value of a bus is its output while the block drives it, and its input otherwise.
- R2: Loading takes place whatever the values of `oe_n` and `dir`, isolation included.
- R3: While `oe_n` is 1, both output-enable vectors of the section are all zeros and both output vectors are zero.
- R4: With `oe_n`=0 and `dir`=0, `a_oe` is all ones and `b_oe` is all zeros. `a_out` equals live `b_in` when `sel_b`=0 and the B-side register when `sel_b`=1. `b_out` is zero.
- R5: With `oe_n`=0 and `dir`=1, `b_oe` is all ones and `a_oe` is all zeros. `b_out` equals live `a_in` when `sel_a`=0 and the A-side register when `sel_a`=1. `a_out` is zero.
- R6: The A and B output enables of a section are never active together, and each enable vector is either all ones or all zeros across its byte.
- R7: A register keeps its value while its capture clock stays static, even when its bus input changes.
- R8: A rising capture-clock edge while `rst` is 1 clears that register to zero.
- R9: While the block drives a bus, a capture edge for that bus stores the value the block is driving onto it.
- R10: The sections are independent: the controls and data of one section have no effect on the outputs or registers of another.
- R11: With both sources held steady, a change of a select input moves the driven output directly from the old source to the new one. The select path is a per-bit two-input AND-OR network and holds no state of its own.

Port `[s*WIDTH +: WIDTH]` of every bus vector, and bit `s` of every control vector, belong to section `s`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, applied at capture-clock edges |
| clk_ab | input | SECTIONS | A-side capture clock, one bit per section |
| clk_ba | input | SECTIONS | B-side capture clock, one bit per section |
| sel_a | input | SECTIONS | 1 sends the A-side register to bus B, 0 sends live bus A |
| sel_b | input | SECTIONS | 1 sends the B-side register to bus A, 0 sends live bus B |
| dir | input | SECTIONS | 0 drives bus A, 1 drives bus B |
| oe_n | input | SECTIONS | Active-low output enable; 1 isolates both buses |
| a_in | input | SECTIONS*WIDTH | Value present on bus A pins |
| a_out | output | SECTIONS*WIDTH | Value driven onto bus A |
| a_oe | output | SECTIONS*WIDTH | Per-bit drive enable for bus A |
| b_in | input | SECTIONS*WIDTH | Value present on bus B pins |
| b_out | output | SECTIONS*WIDTH | Value driven onto bus B |
| b_oe | output | SECTIONS*WIDTH | Per-bit drive enable for bus B |

## Verification
The load checks assume that `rst` is held high through the first capture edges of both clocks of every section. They also assume that each register's data input is steady around its capture edge. The stimulus therefore changes all data and control inputs early in a cycle and raises the capture clocks half a nanosecond later. It lowers the clocks well before outputs are sampled. In the bench the capture clocks are plain pulses timed off the bench clock, so a register's value changes only at a bench-chosen instant, never at an edge the design might see out of order.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Which bus of a section the block is currently driving.
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;
endpackage

// File: rtl/xcvr_cap_reg.sv
`timescale 1ns/1ps
module xcvr_cap_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1: every capture edge outside reset loads the data present at that edge
  a_r1_load: assert property (@(posedge clk) disable iff (rst) !rst |=> q == $past(d));
endmodule

// File: rtl/xcvr_ctrl.sv
`timescale 1ns/1ps
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e drive
);
  always_comb begin
    if (oe_n)     drive = DRV_NONE;
    else if (dir) drive = DRV_B;
    else          drive = DRV_A;
  end
endmodule

// File: rtl/xcvr_sel.sv
`timescale 1ns/1ps
module xcvr_sel #(
  parameter int WIDTH = 8
) (
  input  logic             sel_stored,
  input  logic             drive_en,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);
  logic [WIDTH-1:0] sel_v;
  logic [WIDTH-1:0] en_v;

  // AND-OR form: each bit is one of the two sources, with no other state
  assign sel_v = {WIDTH{sel_stored}};
  assign en_v  = {WIDTH{drive_en}};
  assign out   = en_v & ((live & ~sel_v) | (stored & sel_v));
endmodule

// File: rtl/xcvr_section.sv
`timescale 1ns/1ps
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rst,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             dir,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  drive_e           drive;
  logic             drv_a;
  logic             drv_b;
  logic [WIDTH-1:0] reg_a;
  logic [WIDTH-1:0] reg_b;
  logic [WIDTH-1:0] bus_a;
  logic [WIDTH-1:0] bus_b;

  xcvr_ctrl u_ctrl (
    .oe_n  (oe_n),
    .dir   (dir),
    .drive (drive)
  );

  assign drv_a = (drive == DRV_A);
  assign drv_b = (drive == DRV_B);
  assign a_oe  = {WIDTH{drv_a}};
  assign b_oe  = {WIDTH{drv_b}};

  xcvr_sel #(.WIDTH(WIDTH)) u_sel_to_a (
    .sel_stored (sel_b),
    .drive_en   (drv_a),
    .live       (b_in),
    .stored     (reg_b),
    .out        (a_out)
  );

  xcvr_sel #(.WIDTH(WIDTH)) u_sel_to_b (
    .sel_stored (sel_a),
    .drive_en   (drv_b),
    .live       (a_in),
    .stored     (reg_a),
    .out        (b_out)
  );

  // Resolved pin value: what the block drives, else what arrives
  assign bus_a = drv_a ? a_out : a_in;
  assign bus_b = drv_b ? b_out : b_in;

  xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk (clk_ab),
    .rst (rst),
    .d   (bus_a),
    .q   (reg_a)
  );

  xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk (clk_ba),
    .rst (rst),
    .d   (bus_b),
    .q   (reg_b)
  );

  always_comb begin
    // R6: never both sides enabled
    a_r6_exclusive: assert (!((|a_oe) && (|b_oe)));
    // R6: enables uniform across the byte
    a_r6_uniform_a: assert (a_oe == '0 || a_oe == '1);
    a_r6_uniform_b: assert (b_oe == '0 || b_oe == '1);
    // R3: isolation leaves both buses undriven
    if (oe_n) begin
      a_r3_isolate: assert (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0);
    end
  end
endmodule

// File: rtl/dual_xcvr_reg.sv
`timescale 1ns/1ps
module dual_xcvr_reg #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input  logic                      rst,
  input  logic [SECTIONS-1:0]       clk_ab,
  input  logic [SECTIONS-1:0]       clk_ba,
  input  logic [SECTIONS-1:0]       sel_a,
  input  logic [SECTIONS-1:0]       sel_b,
  input  logic [SECTIONS-1:0]       dir,
  input  logic [SECTIONS-1:0]       oe_n,
  input  logic [SECTIONS*WIDTH-1:0] a_in,
  output logic [SECTIONS*WIDTH-1:0] a_out,
  output logic [SECTIONS*WIDTH-1:0] a_oe,
  input  logic [SECTIONS*WIDTH-1:0] b_in,
  output logic [SECTIONS*WIDTH-1:0] b_out,
  output logic [SECTIONS*WIDTH-1:0] b_oe
);
  localparam int BUS_W = SECTIONS * WIDTH;

  logic [BUS_W-1:0] a_out_w;
  logic [BUS_W-1:0] a_oe_w;
  logic [BUS_W-1:0] b_out_w;
  logic [BUS_W-1:0] b_oe_w;

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    xcvr_section #(.WIDTH(WIDTH)) u_sec (
      .rst    (rst),
      .clk_ab (clk_ab[s]),
      .clk_ba (clk_ba[s]),
      .sel_a  (sel_a[s]),
      .sel_b  (sel_b[s]),
      .dir    (dir[s]),
      .oe_n   (oe_n[s]),
      .a_in   (a_in[s*WIDTH +: WIDTH]),
      .a_out  (a_out_w[s*WIDTH +: WIDTH]),
      .a_oe   (a_oe_w[s*WIDTH +: WIDTH]),
      .b_in   (b_in[s*WIDTH +: WIDTH]),
      .b_out  (b_out_w[s*WIDTH +: WIDTH]),
      .b_oe   (b_oe_w[s*WIDTH +: WIDTH])
    );
  end

  assign a_out = a_out_w;
  assign a_oe  = a_oe_w;
  assign b_out = b_out_w;
  assign b_oe  = b_oe_w;
endmodule

// File: tb/test_dual_xcvr_reg.sv
`timescale 1ns/1ps
module test_dual_xcvr_reg;
  localparam int S = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic [S-1:0] clk_ab = '0, clk_ba = '0;
  logic [S-1:0] sel_a = '0, sel_b = '0, dir = '0, oe_n = '1;
  logic [S*W-1:0] a_in = '0, b_in = '0;
  logic [S*W-1:0] a_out, a_oe, b_out, b_oe;

  // staged next-cycle inputs
  logic         n_rst = 1'b1;
  logic [S-1:0] n_sel_a = '0, n_sel_b = '0, n_dir = '0, n_oe_n = '1;
  logic [S*W-1:0] n_a_in = '0, n_b_in = '0;

  dual_xcvr_reg #(.SECTIONS(S), .WIDTH(W)) i_dual_xcvr_reg (
    .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_a(sel_a), .sel_b(sel_b),
    .dir(dir), .oe_n(oe_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // behavioural reference state
  logic [W-1:0] m_ra [S];
  logic [W-1:0] m_rb [S];
  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;
  string tag = "R8";

  function automatic logic drives_a(int s); return !oe_n[s] && !dir[s]; endfunction
  function automatic logic drives_b(int s); return !oe_n[s] &&  dir[s]; endfunction

  function automatic logic [W-1:0] exp_a_out(int s);
    if (!drives_a(s)) return '0;
    return sel_b[s] ? m_rb[s] : b_in[s*W +: W];
  endfunction

  function automatic logic [W-1:0] exp_b_out(int s);
    if (!drives_b(s)) return '0;
    return sel_a[s] ? m_ra[s] : a_in[s*W +: W];
  endfunction

  // One bench cycle: apply staged inputs, optionally pulse capture clocks
  task automatic step(input logic [S-1:0] pab, input logic [S-1:0] pba);
    logic [W-1:0] na [S];
    logic [W-1:0] nb [S];
    @(posedge clk);
    #0.5;
    rst = n_rst; sel_a = n_sel_a; sel_b = n_sel_b; dir = n_dir; oe_n = n_oe_n;
    a_in = n_a_in; b_in = n_b_in;
    #0.5;
    for (int s = 0; s < S; s++) begin
      na[s] = drives_a(s) ? exp_a_out(s) : a_in[s*W +: W];   // R9 resolved bus
      nb[s] = drives_b(s) ? exp_b_out(s) : b_in[s*W +: W];
    end
    for (int s = 0; s < S; s++) begin
      if (pab[s]) m_ra[s] = rst ? '0 : na[s];
      if (pba[s]) m_rb[s] = rst ? '0 : nb[s];
    end
    clk_ab = pab; clk_ba = pba;
    #1;
    clk_ab = '0; clk_ba = '0;
  endtask

  // compare every clock, away from the edges the bench drives on
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      for (int s = 0; s < S; s++) begin
        logic [W-1:0] ea_oe, eb_oe;
        ea_oe = {W{drives_a(s)}};
        eb_oe = {W{drives_b(s)}};
        checks++;
        if (a_out[s*W +: W] !== exp_a_out(s) || b_out[s*W +: W] !== exp_b_out(s) ||
            a_oe[s*W +: W] !== ea_oe || b_oe[s*W +: W] !== eb_oe) begin
          fails++;
          $display("FAIL %s sec%0d a_out=%h/%h b_out=%h/%h a_oe=%h/%h b_oe=%h/%h (got/exp)",
                   tag, s, a_out[s*W +: W], exp_a_out(s), b_out[s*W +: W], exp_b_out(s),
                   a_oe[s*W +: W], ea_oe, b_oe[s*W +: W], eb_oe);
        end
        checks++;
        // R6 exclusive enables, checked at the ports
        if ((|a_oe[s*W +: W]) && (|b_oe[s*W +: W])) begin
          fails++;
          $display("FAIL R6 sec%0d both enables active a_oe=%h b_oe=%h exp one idle",
                   s, a_oe[s*W +: W], b_oe[s*W +: W]);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < S; s++) begin m_ra[s] = '0; m_rb[s] = '0; end
    // R8: reset clears both registers at capture edges
    n_rst = 1'b1; n_a_in = 16'hA5C3; n_b_in = 16'h3C5A;
    step('1, '1);
    step('1, '1);
    n_rst = 1'b0;
    n_oe_n = '0; n_dir = '0; n_sel_b = '1;  // R8 stored B visible on A: zero
    step('0, '0);
    cmp_en = 1'b1;
    step('0, '0);
    n_dir = '1; n_sel_a = '1;               // R8 stored A visible on B: zero
    step('0, '0);

    // R4 live B to A under several patterns
    tag = "R4";
    n_dir = '0; n_sel_b = '0;
    n_b_in = 16'h00FF; step('0, '0);
    n_b_in = 16'h55AA; step('0, '0);
    n_b_in = 16'hFF00; step('0, '0);

    // R2, R3 capture during isolation
    tag = "R2";
    n_oe_n = '1; n_a_in = 16'h1234; n_b_in = 16'h9876;
    step('1, '0);
    step('0, '1);
    tag = "R3";
    step('0, '0);

    // R5 stored and live A to B; R1 value captured above
    tag = "R5";
    n_oe_n = '0; n_dir = '1; n_sel_a = '1; step('0, '0);
    n_sel_a = '0; n_a_in = 16'hBEEF; step('0, '0);

    // R7 register holds while clock static
    tag = "R7";
    n_sel_a = '1; n_a_in = 16'h0F0F; step('0, '0);
    n_a_in = 16'hF0F0; step('0, '0);

    // R1 load while driving the other side
    tag = "R1";
    n_a_in = 16'h6B21; step('1, '0);
    step('0, '0);

    // R9 capture of the driven bus B (live A passed through)
    tag = "R9";
    n_sel_a = '0; n_a_in = 16'hC0DE; n_b_in = 16'h1111;
    step('0, '1);
    n_dir = '0; n_sel_b = '1; n_b_in = 16'h2222; step('0, '0);
    // R9 on bus A: driven stored B, captured into A register
    step('1, '0);
    n_dir = '1; n_sel_a = '1; step('0, '0);

    // R11 select toggles with steady sources
    tag = "R11";
    for (int k = 0; k < 6; k++) begin
      n_sel_a = ~n_sel_a; step('0, '0);
    end

    // R10 independent sections with differing controls
    tag = "R10";
    n_oe_n = 2'b10; n_dir = 2'b01; n_sel_a = 2'b01; n_sel_b = 2'b10;
    n_a_in = 16'h4477; n_b_in = 16'h88CC;
    step(2'b10, 2'b01);
    step(2'b01, 2'b10);
    step('0, '0);

    // R10 and all others: mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      n_oe_n  = S'($urandom); n_dir   = S'($urandom);
      n_sel_a = S'($urandom); n_sel_b = S'($urandom);
      n_a_in  = (S*W)'($urandom); n_b_in = (S*W)'($urandom);
      step(S'($urandom), S'($urandom));
    end

    step('0, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule